// File: doc/BRIEF.md
# Multi-Slot Serial Sample Formatter

This block turns one set of per-sample values into a serial bit stream. The values are an I/Q pair, magnitude, phase, a second I/Q pair and a gain word. A sample strobe captures all seven 24-bit signed values. After the strobe the block walks through seven time slots in a fixed order. Each slot has its own 8-bit descriptor, which picks a source value, an output word width and an optional sync pulse. The selected value is rounded and saturated to that width, then driven MSB first at one bit per clock. A data-valid output marks which clocks carry data.

The seven descriptors come from two 32-bit configuration words, which are held static while the block runs. A slot whose descriptor is all zero sends nothing but still takes one clock. A descriptor with a float or undefined width code behaves the same way and also sets a sticky error flag. A new strobe always wins over the slot sequence: the transfer in progress is dropped, slot 1 of the new sample starts on the next clock, and no sync owed to the old sample is ever sent.

Top module: `serial_slot_formatter`

## Requirements
- R1: Slot k (k = 1..4) takes its descriptor from `cfg_lo[8k-1:8k-8]`. Slots 5, 6 and 7 take theirs from `cfg_hi[7:0]`, `cfg_hi[15:8]` and `cfg_hi[23:16]`. `cfg_hi[31:24]` has no effect on the output.
- R2: Descriptor bits 6:3 select the slot length. Codes 0..9 give 1, 4, 6, 8, 10, 12, 16, 20, 24 and 32 bit clocks. A data slot lasts exactly that many clocks, and the next slot follows with no gap.
- R3: Descriptor bits 2:0 select the source. 0 sends zeros. 1 to 7 send the captured I1, Q1, magnitude, phase, I2, Q2 and gain values.
- R4: For widths below 24, the output is the two's complement of floor((v + 2^(23-W)) / 2^(24-W)). Here v is the 24-bit source value and W is the slot width.
- R5: A rounded value above 2^(W-1)-1 is sent as 2^(W-1)-1. A value below -2^(W-1) is sent as -2^(W-1). The 1-bit width saturates to the range -1..0.
- R6: Width 24 sends the 24-bit source value unchanged. Width 32 sends the 24-bit source value followed by eight zero bits.
- R7: A descriptor of 00h takes one clock, with `sd_valid` low and `sd_out` low.
- R8: `sd_sync` is a one-clock pulse on the MSB clock of any data slot whose descriptor has bit 7 set. It never occurs outside data slots.
- R9: When `smp_stb` is high at an edge, slot 1 of the newly captured sample is driven from the next clock, whatever was in progress. Syncs from the abandoned sample are not generated.
- R10: Width codes 10..15 take one idle clock with valid and sync low, and set `cfg_err`. `cfg_err` stays set until reset and is 0 until such a slot occurs.
- R11: After reset, and after slot 7 until the next strobe, `sd_valid`, `sd_out` and `sd_sync` are low.
- R12: During a data slot, `sd_valid` is high on every clock and bits go out MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo | input | 32 | Descriptors for slots 1 to 4 |
| cfg_hi | input | 32 | Descriptors for slots 5 to 7 in bits 23:0 |
| smp_stb | input | 1 | Sample strobe: captures the values and restarts the sequence |
| i1_in | input | 24 | First I value, signed |
| q1_in | input | 24 | First Q value, signed |
| mag_in | input | 24 | Magnitude, signed |
| phs_in | input | 24 | Phase, signed |
| i2_in | input | 24 | Second I value, signed |
| q2_in | input | 24 | Second Q value, signed |
| agc_in | input | 24 | Gain value, signed |
| sd_out | output | 1 | Serial data, MSB first |
| sd_valid | output | 1 | High on clocks that carry data |
| sd_sync | output | 1 | Sync pulse on the first bit of flagged slots |
| cfg_err | output | 1 | Sticky flag for an undefined width code |

## Verification
The bench sweeps every width code against every source and compares each clock with a bit stream it computes arithmetically. It places values exactly on the half-LSB rounding point and at both full-scale limits. A design that truncated instead of rounding, or that wrapped instead of saturating, would flip sign bits on those values. Zero descriptors and undefined width codes sit between data slots, so a design that skipped the idle clock, or gave it a full width, would shift every later slot. The bench also restarts a sequence in the middle of a slot and on its last bit, and then expects the new slot 1 at once with only the new syncs. A design that finished the old sample, or let an old sync through, would show a mismatch.

// File: rtl/serial_slot_formatter.sv
module serial_slot_formatter #(
  parameter int SRC_W = 24,
  parameter int SLOTS = 7,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_lo,
  input  logic [CFG_W-1:0] cfg_hi,
  input  logic             smp_stb,
  input  logic [SRC_W-1:0] i1_in,
  input  logic [SRC_W-1:0] q1_in,
  input  logic [SRC_W-1:0] mag_in,
  input  logic [SRC_W-1:0] phs_in,
  input  logic [SRC_W-1:0] i2_in,
  input  logic [SRC_W-1:0] q2_in,
  input  logic [SRC_W-1:0] agc_in,
  output logic             sd_out,
  output logic             sd_valid,
  output logic             sd_sync,
  output logic             cfg_err
);
  localparam int WORD_W = 32;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int LEN_W  = CNT_W + 1;
  localparam logic [SLOT_W-1:0] IDLE = SLOT_W'(SLOTS);

  logic [2*CFG_W-1:0] cfg_all;
  logic [SRC_W-1:0]   samp [1:7];
  logic [SLOT_W-1:0]  slot;
  logic [CNT_W-1:0]   bitc;
  logic [7:0]         d;
  logic [LEN_W-1:0]   len;
  logic [SRC_W-1:0]   sel;
  logic [WORD_W-1:0]  word;
  logic               en, last_bit;

  function automatic logic [LEN_W-1:0] code_len(input logic [3:0] c);
    case (c)
      4'd0: return LEN_W'(1);
      4'd1: return LEN_W'(4);
      4'd2: return LEN_W'(6);
      4'd3: return LEN_W'(8);
      4'd4: return LEN_W'(10);
      4'd5: return LEN_W'(12);
      4'd6: return LEN_W'(16);
      4'd7: return LEN_W'(20);
      4'd8: return LEN_W'(24);
      4'd9: return LEN_W'(32);
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] fmt(input logic signed [SRC_W-1:0] v,
                                            input logic [LEN_W-1:0] wl);
    logic signed [SRC_W:0] s, q, hi, lo;
    int w;
    w = int'(wl);
    if (w >= SRC_W) return WORD_W'($unsigned(v)) << (WORD_W - SRC_W);
    s  = {v[SRC_W-1], v} + ((SRC_W+1)'(1) << (SRC_W - 1 - w));
    q  = s >>> (SRC_W - w);
    hi = ((SRC_W+1)'(1) << (w - 1)) - (SRC_W+1)'(1);
    lo = ~hi;
    if (q > hi) q = hi;
    else if (q < lo) q = lo;
    return WORD_W'(q) << (WORD_W - w);
  endfunction

  assign cfg_all  = {cfg_hi, cfg_lo};
  assign d        = (slot != IDLE) ? cfg_all[{slot, 3'b000} +: 8] : 8'h00;
  assign len      = code_len(d[6:3]);
  assign en       = (slot != IDLE) && (d != 8'h00) && (len != '0);
  assign sel      = (d[2:0] == 3'd0) ? '0 : samp[d[2:0]];
  assign word     = fmt(sel, len);
  assign last_bit = (bitc == CNT_W'(len - LEN_W'(1)));

  assign sd_valid = en;
  assign sd_out   = en & word[WORD_W - 1 - int'(bitc)];
  assign sd_sync  = en & (bitc == '0) & d[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= IDLE;
      bitc    <= '0;
      cfg_err <= 1'b0;
      for (int k = 1; k <= 7; k++) samp[k] <= '0;
    end else begin
      if (slot != IDLE && d != 8'h00 && len == '0) cfg_err <= 1'b1;
      if (smp_stb) begin
        samp[1] <= i1_in;
        samp[2] <= q1_in;
        samp[3] <= mag_in;
        samp[4] <= phs_in;
        samp[5] <= i2_in;
        samp[6] <= q2_in;
        samp[7] <= agc_in;
        slot    <= '0;
        bitc    <= '0;
      end else if (slot != IDLE) begin
        if (!en || last_bit) begin
          slot <= slot + SLOT_W'(1);
          bitc <= '0;
        end else begin
          bitc <= bitc + CNT_W'(1);
        end
      end
    end
  end

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (slot == '0 && bitc == '0));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == IDLE && !smp_stb) |=> (slot == IDLE && !sd_valid && !sd_sync));

  p_bit_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && en && !last_bit) |=> (bitc == $past(bitc) + CNT_W'(1) && $stable(slot)));

  p_empty_one_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && slot != IDLE && d == 8'h00) |=> (slot == $past(slot) + SLOT_W'(1) && bitc == '0));
endmodule

// File: tb/tb_serial_slot_formatter.sv
`timescale 1ns/1ps
module tb_serial_slot_formatter;
  logic clk = 0, rst_n = 0, smp_stb = 0;
  logic signed [23:0] vals [1:7];
  logic [7:0] dsc [0:6];
  logic [7:0] junk;
  logic [31:0] cfg_lo, cfg_hi;
  logic sd_out, sd_valid, sd_sync, cfg_err;
  int checks = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  assign cfg_lo = {dsc[3], dsc[2], dsc[1], dsc[0]};
  assign cfg_hi = {junk, dsc[6], dsc[5], dsc[4]};

  serial_slot_formatter dut (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .smp_stb(smp_stb),
    .i1_in(vals[1]), .q1_in(vals[2]), .mag_in(vals[3]), .phs_in(vals[4]),
    .i2_in(vals[5]), .q2_in(vals[6]), .agc_in(vals[7]),
    .sd_out(sd_out), .sd_valid(sd_valid), .sd_sync(sd_sync), .cfg_err(cfg_err));

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic int blen(input int c);
    case (c)
      0: return 1;  1: return 4;  2: return 6;  3: return 8;  4: return 10;
      5: return 12; 6: return 16; 7: return 20; 8: return 24; 9: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic bit xbit(input logic signed [23:0] x, input int w, input int b);
    longint q, hi;
    if (w >= 24) return (b < 24) ? x[23-b] : 1'b0;
    q  = (longint'(x) + (longint'(1) << (23 - w))) >>> (24 - w);
    hi = (longint'(1) << (w - 1)) - 1;
    if (q > hi) q = hi;
    if (q < -hi - 1) q = -hi - 1;
    return q[w-1-b];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, a, e);
    end
  endtask

  task automatic rand_vals();
    for (int k = 1; k <= 7; k++) vals[k] = 24'(rnd() >> 5);
  endtask

  task automatic run(input int cut, input string req);
    int cyc, w, n;
    bit stop, en, ok;
    logic [7:0] d;
    logic [2:0] act, exp, fa, fe;
    logic signed [23:0] x;
    cyc = 0; stop = 0;
    smp_stb = 1;
    @(negedge clk);
    smp_stb = 0;
    for (int s = 0; s < 7; s++) begin
      d  = dsc[s];
      w  = blen(int'(d[6:3]));
      en = (d != 8'h00) && (w != 0);
      n  = en ? w : 1;
      ok = 1; fa = 0; fe = 0;
      x  = (d[2:0] == 3'd0) ? 24'sd0 : vals[d[2:0]];
      for (int b = 0; b < n; b++) begin
        if (cut > 0 && cyc == cut) begin stop = 1; break; end
        exp = {en, en ? xbit(x, w, b) : 1'b0, en && b == 0 && d[7]};
        act = {sd_valid, sd_out, sd_sync};
        if (act !== exp && ok) begin ok = 0; fa = act; fe = exp; end
        cyc++;
        @(negedge clk);
      end
      chk(ok, req, $sformatf("slot %0d {valid,data,sync}", s + 1), 32'(fa), 32'(fe));
      if (stop) break;
    end
    if (!stop) begin
      ok = 1; fa = 0;
      repeat (3) begin
        if ({sd_valid, sd_out, sd_sync} !== 3'b000) begin ok = 0; fa = {sd_valid, sd_out, sd_sync}; end
        @(negedge clk);
      end
      chk(ok, "R11", "idle after last slot", 32'(fa), 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int h;
    for (int k = 0; k < 7; k++) dsc[k] = 8'h00;
    for (int k = 1; k <= 7; k++) vals[k] = '0;
    junk = 8'h00;
    repeat (3) @(negedge clk);
    chk({sd_valid, sd_out, sd_sync, cfg_err} == 4'b0000, "R11", "reset outputs",
        32'({sd_valid, sd_out, sd_sync, cfg_err}), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R12: every width code against every source
    for (int c = 0; c < 10; c++)
      for (int t = 0; t < 8; t++) begin
        for (int k = 0; k < 7; k++) dsc[k] = {1'b0, 4'(c), 3'((t + k) % 8)};
        if (dsc[0] == 8'h00) dsc[0] = 8'h01;
        junk = 8'(rnd());
        rand_vals();
        run(0, "R2 R3 R12");
      end

    // R4 R5: half-LSB points and full-scale limits
    for (int c = 0; c < 8; c++) begin
      h = 1 << (23 - blen(c));
      vals[1] = 24'(h - 1); vals[2] = 24'(h); vals[3] = 24'(-h); vals[4] = 24'(-h - 1);
      vals[5] = 24'h7FFFFF; vals[6] = 24'h800000; vals[7] = 24'(24'h7FFFFF - h + 1);
      for (int k = 0; k < 7; k++) dsc[k] = {1'b0, 4'(c), 3'(k + 1)};
      run(0, "R4 R5");
    end

    // R6: full width and padded width
    for (int r = 0; r < 6; r++) begin
      rand_vals();
      for (int k = 0; k < 7; k++) dsc[k] = {1'b0, (r % 2 == 0) ? 4'd8 : 4'd9, 3'(k + 1)};
      run(0, "R6");
    end

    // R7: empty slots keep one clock
    dsc[0] = {1'b0, 4'd6, 3'd1}; dsc[1] = 8'h00; dsc[2] = {1'b0, 4'd6, 3'd2};
    dsc[3] = 8'h00; dsc[4] = 8'h00; dsc[5] = {1'b0, 4'd0, 3'd3}; dsc[6] = {1'b0, 4'd3, 3'd4};
    rand_vals(); run(0, "R7");
    for (int k = 0; k < 7; k++) dsc[k] = 8'h00;
    dsc[6] = {1'b0, 4'd2, 3'd7};
    rand_vals(); run(0, "R7");

    // R8: sync flags, including a one-bit zero slot
    dsc[0] = 8'h80; dsc[1] = {1'b1, 4'd0, 3'd1}; dsc[2] = {1'b0, 4'd1, 3'd2};
    dsc[3] = {1'b1, 4'd5, 3'd5}; dsc[4] = 8'h00; dsc[5] = {1'b1, 4'd9, 3'd7}; dsc[6] = {1'b1, 4'd3, 3'd6};
    rand_vals(); run(0, "R8");

    // R1: byte order and the unused top byte
    junk = 8'hFF;
    for (int k = 0; k < 7; k++) dsc[k] = {k[0], 4'(k + 1), 3'(7 - k)};
    rand_vals(); run(0, "R1");
    junk = 8'h5A; rand_vals(); run(0, "R1");
    chk(cfg_err == 1'b0, "R10", "no error before undefined code", 32'(cfg_err), 32'd0);

    // R10: undefined width codes
    for (int c = 10; c < 16; c++) begin
      dsc[0] = {1'b0, 4'd3, 3'd1}; dsc[1] = {1'b1, 4'(c), 3'd2}; dsc[2] = {1'b1, 4'd4, 3'd3};
      dsc[3] = {1'b0, 4'(c), 3'd0}; dsc[4] = {1'b0, 4'd1, 3'd5}; dsc[5] = 8'h00; dsc[6] = {1'b1, 4'(c), 3'd7};
      rand_vals(); run(0, "R10");
    end
    chk(cfg_err == 1'b1, "R10", "error flag set", 32'(cfg_err), 32'd1);
    for (int k = 0; k < 7; k++) dsc[k] = {1'b0, 4'd3, 3'(k + 1)};
    rand_vals(); run(0, "R10");
    chk(cfg_err == 1'b1, "R10", "error flag sticky", 32'(cfg_err), 32'd1);

    // R9: preemption mid slot, at a slot boundary and on the first bit
    for (int k = 0; k < 7; k++) dsc[k] = {1'b1, 4'd9, 3'(k + 1)};
    rand_vals(); run(40, "R9");
    rand_vals(); run(32, "R9");
    rand_vals(); run(1, "R9");
    rand_vals(); run(223, "R9");
    rand_vals(); run(0, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule